// File: doc/BRIEF.md
# I2C SCL Clock Timing Generator

This block derives the serial clock waveform for an I2C bus master from the system clock. The SCL period is set by three programmed values: a base exponent that selects a power-of-two prescaler, a count for the high half of the clock and a count for the low half. The two counts are stored minus one, so a count of zero gives one prescaled cycle. The generator drives the SCL level and a per-cycle prescaler tick. It also gives a byte engine a phase flag and four one-cycle strobes: one at the start of each phase, one mid-high for sampling SDA and one mid-low for changing SDA.

Software loads a 32-bit timing word. Bits 31:20 hold bus-free, start-hold and similar fields that other logic consumes. A load can either replace them or keep them while updating only the clock fields. New clock fields are applied only where a low phase ends and a high phase begins, so a reload never shortens a pulse. A build parameter selects counters of 3 bits (narrow) or 4 bits (wide) for the high and low phases.

Top module: `scl_timing_gen`

## Requirements
- R1: While enabled, the low phase lasts (L+1)·2^B system cycles and the high phase (H+1)·2^B cycles. Here B is timing bits 3:0, H is bits 19:16 and L is bits 15:12. The phases alternate, and the SCL output and the phase flag are high exactly during the high phase.
- R2: The active timing word reads back on `timing_q` as {bits 31:20, H, L, 8'h00, B}. Bits 11:4 always read zero.
- R3: A count field of zero yields a phase of exactly one prescaled period, including at the largest exponent exercised (B=4 gives 16 cycles per phase).
- R4: With WIDE_CNT=1 each phase count uses all four bits, up to 16 prescaled periods. With WIDE_CNT=0 only bits 18:16 and 14:12 count, up to 8 periods, and bits 19 and 15 are ignored and read back as zero.
- R5: A load with `ld_keep_hi`=1 leaves timing bits 31:20 unchanged. A load with `ld_keep_hi`=0 replaces them on the next clock edge.
- R6: While running, loaded clock fields wait and become active at the next low-to-high phase boundary. Until then, the current phase and the following low phase keep the old values. While stopped, a load becomes active on the next edge.
- R7: While disabled, `scl_o` is 1, and `scl_hi_ph`, `pre_tick` and all strobes are 0. The cycle after `enable` is sampled high, a low phase begins with `fall_stb`.
- R8: `fall_stb` is high only in the first cycle of each low phase, and `rise_stb` only in the first cycle of each high phase.
- R9: `chg_stb` pulses once per low phase, at offset (L>>1)·2^B cycles from the phase start. `samp_stb` pulses once per high phase, at offset (H>>1)·2^B cycles.
- R10: `pre_tick` pulses in the last cycle of every 2^B-cycle prescaler period, giving L+1 ticks per low phase and H+1 per high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Run the SCL generator |
| ld_en | input | 1 | Load `ld_data` into the timing word |
| ld_keep_hi | input | 1 | On a load, keep bits 31:20 and update only the clock fields |
| ld_data | input | 32 | Timing word to load |
| timing_q | output | 32 | Active timing word |
| scl_o | output | 1 | SCL level (released high when disabled) |
| scl_hi_ph | output | 1 | High-phase flag |
| pre_tick | output | 1 | Prescaler period end |
| rise_stb | output | 1 | First cycle of a high phase |
| fall_stb | output | 1 | First cycle of a low phase |
| samp_stb | output | 1 | Mid-high strobe for sampling SDA |
| chg_stb | output | 1 | Mid-low strobe for changing SDA |

## Verification
A corrupted prescaler or phase counter shows up within one SCL phase. It appears as a phase of the wrong length, a missing or doubled tick, or a mid strobe at the wrong offset, and the scoreboard compares each of these at the end of the phase. A pending-field error stays hidden until the next low-to-high boundary, so the reload test checks the old clock fields right after the write and the new phase lengths one and a half periods later. Errors in the upper field and in the narrow-width masking show on `timing_q` one edge after the load.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BASE_W  = 4;
  localparam int unsigned FLD_W   = 4;
  localparam int unsigned KEEP_W  = 12;
  localparam int unsigned BASE_LSB = 0;
  localparam int unsigned LO_LSB   = 12;
  localparam int unsigned HI_LSB   = 16;
  localparam int unsigned KEEP_LSB = 20;

  typedef struct packed {
    logic [FLD_W-1:0]  hi;
    logic [FLD_W-1:0]  lo;
    logic [BASE_W-1:0] base;
  } clk_fields_t;
endpackage

// File: rtl/scl_tg_cfg.sv
module scl_tg_cfg
  import scl_tg_pkg::*;
#(
  parameter bit WIDE_CNT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 run,
  input  logic                 boundary,
  input  logic                 ld_en,
  input  logic                 ld_keep_hi,
  input  logic [WORD_W-1:0]    ld_data,
  output clk_fields_t          act_o,
  output logic [KEEP_W-1:0]    keep_o
);
  clk_fields_t       wr_f;
  clk_fields_t       act_q, act_d;
  clk_fields_t       pend_q, pend_d;
  logic              pv_q, pv_d;
  logic [KEEP_W-1:0] keep_q, keep_d;

  assign wr_f.base = ld_data[BASE_LSB +: BASE_W];

  generate
    if (WIDE_CNT) begin : g_wide
      assign wr_f.hi = ld_data[HI_LSB +: FLD_W];
      assign wr_f.lo = ld_data[LO_LSB +: FLD_W];
    end else begin : g_narrow
      assign wr_f.hi = {1'b0, ld_data[HI_LSB +: FLD_W-1]};
      assign wr_f.lo = {1'b0, ld_data[LO_LSB +: FLD_W-1]};
    end
  endgenerate

  always_comb begin
    act_d  = act_q;
    pend_d = pend_q;
    pv_d   = pv_q;
    keep_d = keep_q;
    if (boundary && pv_q) begin
      act_d = pend_q;
      pv_d  = 1'b0;
    end
    if (ld_en) begin
      if (!ld_keep_hi) begin
        keep_d = ld_data[KEEP_LSB +: KEEP_W];
      end
      if (!run) begin
        act_d = wr_f;
        pv_d  = 1'b0;
      end else begin
        pend_d = wr_f;
        pv_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      pend_q <= '0;
      pv_q   <= 1'b0;
      keep_q <= '0;
    end else begin
      act_q  <= act_d;
      pend_q <= pend_d;
      pv_q   <= pv_d;
      keep_q <= keep_d;
    end
  end

  assign act_o  = act_q;
  assign keep_o = keep_q;

  AST_CLK_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_ni)
    (run && !boundary) |=> $stable(act_q)); // R6
  AST_KEEP_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    (ld_en && ld_keep_hi) |=> $stable(keep_q)); // R5
endmodule

// File: rtl/scl_tg_presc.sv
module scl_tg_presc
  import scl_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              run,
  input  logic [BASE_W-1:0] base,
  output logic              tick_o,
  output logic              pc_zero_o
);
  localparam int unsigned PC_W = (1 << BASE_W) - 1;

  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W-1:0] pmax;
  logic            tick;

  assign pmax = ~({PC_W{1'b1}} << base);
  assign tick = run && (pc_q == pmax);

  always_comb begin
    pc_d = pc_q;
    if (!run || tick) begin
      pc_d = '0;
    end else begin
      pc_d = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign tick_o    = tick;
  assign pc_zero_o = (pc_q == '0);

  AST_PC_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_ni)
    !run |=> (pc_q == '0)); // R7
  AST_PC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    run |-> (pc_q <= pmax)); // R10
endmodule

// File: rtl/scl_tg_phase.sv
module scl_tg_phase #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run,
  input  logic             tick,
  input  logic             pc_zero,
  input  logic [CNT_W-1:0] hf,
  input  logic [CNT_W-1:0] lf,
  output logic             hi_o,
  output logic             boundary_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             samp_o,
  output logic             chg_o
);
  logic [CNT_W-1:0] ph_q, ph_d;
  logic             hi_q, hi_d;
  logic [CNT_W-1:0] limit;
  logic             last;
  logic             first;

  assign limit = hi_q ? hf : lf;
  assign last  = tick && (ph_q == limit);

  always_comb begin
    ph_d = ph_q;
    hi_d = hi_q;
    if (!run) begin
      ph_d = '0;
      hi_d = 1'b0;
    end else if (last) begin
      ph_d = '0;
      hi_d = !hi_q;
    end else if (tick) begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
      hi_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      hi_q <= hi_d;
    end
  end

  assign first      = run && pc_zero && (ph_q == '0);
  assign hi_o       = run && hi_q;
  assign boundary_o = last && !hi_q;
  assign rise_o     = first && hi_q;
  assign fall_o     = first && !hi_q;
  assign samp_o     = run && hi_q && pc_zero && (ph_q == (hf >> 1));
  assign chg_o      = run && !hi_q && pc_zero && (ph_q == (lf >> 1));

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (run && !tick) |=> $stable(hi_q)); // R1
  AST_PH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    run |-> (ph_q <= limit)); // R1
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tg_pkg::*;
#(
  parameter bit WIDE_CNT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        ld_en,
  input  logic        ld_keep_hi,
  input  logic [31:0] ld_data,
  output logic [31:0] timing_q,
  output logic        scl_o,
  output logic        scl_hi_ph,
  output logic        pre_tick,
  output logic        rise_stb,
  output logic        fall_stb,
  output logic        samp_stb,
  output logic        chg_stb
);
  localparam int unsigned CNT_W = WIDE_CNT ? FLD_W : FLD_W - 1;
  localparam int unsigned GAP_W = LO_LSB - BASE_W;

  logic              rst_s1, rst_i;
  logic              run_q;
  logic              tick;
  logic              pc_zero;
  logic              boundary;
  logic              hi_ph;
  clk_fields_t       act;
  logic [KEEP_W-1:0] keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      run_q <= 1'b0;
    end else begin
      run_q <= enable;
    end
  end

  scl_tg_cfg #(.WIDE_CNT(WIDE_CNT)) i_cfg (
    .clk        (clk),
    .rst_ni     (rst_i),
    .run        (run_q),
    .boundary   (boundary),
    .ld_en      (ld_en),
    .ld_keep_hi (ld_keep_hi),
    .ld_data    (ld_data),
    .act_o      (act),
    .keep_o     (keep)
  );

  scl_tg_presc i_presc (
    .clk       (clk),
    .rst_ni    (rst_i),
    .run       (run_q),
    .base      (act.base),
    .tick_o    (tick),
    .pc_zero_o (pc_zero)
  );

  scl_tg_phase #(.CNT_W(CNT_W)) i_phase (
    .clk        (clk),
    .rst_ni     (rst_i),
    .run        (run_q),
    .tick       (tick),
    .pc_zero    (pc_zero),
    .hf         (act.hi[CNT_W-1:0]),
    .lf         (act.lo[CNT_W-1:0]),
    .hi_o       (hi_ph),
    .boundary_o (boundary),
    .rise_o     (rise_stb),
    .fall_o     (fall_stb),
    .samp_o     (samp_stb),
    .chg_o      (chg_stb)
  );

  assign timing_q  = {keep, act.hi, act.lo, {GAP_W{1'b0}}, act.base};
  assign scl_o     = run_q ? hi_ph : 1'b1;
  assign scl_hi_ph = hi_ph;
  assign pre_tick  = tick;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_i)
    !run_q |-> (scl_o && !pre_tick && !rise_stb && !fall_stb)); // R7
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0({rise_stb, fall_stb})); // R8
  AST_RISE_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_i)
    (boundary && enable) |=> rise_stb); // R8
endmodule

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;
  typedef struct packed {
    logic hi;
    int   len;
    int   mid;
    int   ticks;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        en_nar = 1'b0;
  logic        ld_en = 1'b0;
  logic        ld_keep_hi = 1'b0;
  logic [31:0] ld_data = '0;

  logic [31:0] timing_q, timing_n;
  logic scl_o, scl_hi_ph, pre_tick, rise_stb, fall_stb, samp_stb, chg_stb;
  logic scl_n, hi_n, tick_n, rise_n, fall_n, samp_n, chg_n;

  int nvec = 0;
  int nerr = 0;
  int cyc  = 0;

  exp_t exp_q[$];
  bit   mon_on = 1'b0;
  bit   trk = 1'b0;
  logic cur_hi;
  int   cnt, mid_at, tk;
  bit   ok;

  always #4 clk = ~clk;

  scl_timing_gen #(.WIDE_CNT(1'b1)) i_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ld_en(ld_en),
    .ld_keep_hi(ld_keep_hi), .ld_data(ld_data), .timing_q(timing_q),
    .scl_o(scl_o), .scl_hi_ph(scl_hi_ph), .pre_tick(pre_tick),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .samp_stb(samp_stb),
    .chg_stb(chg_stb)
  );

  scl_timing_gen #(.WIDE_CNT(1'b0)) i_scl_timing_gen_nar (
    .clk(clk), .rst_n(rst_n), .enable(en_nar), .ld_en(ld_en),
    .ld_keep_hi(ld_keep_hi), .ld_data(ld_data), .timing_q(timing_n),
    .scl_o(scl_n), .scl_hi_ph(hi_n), .pre_tick(tick_n),
    .rise_stb(rise_n), .fall_stb(fall_n), .samp_stb(samp_n),
    .chg_stb(chg_n)
  );

  task automatic chk(input bit cond, input string req, input longint act, input longint exp);
    nvec++;
    if (!cond) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      nerr++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // expected phase derived from R1, R9, R10
  task automatic push_ph(input logic hi, input int f, input int b);
    exp_t e;
    e.hi    = hi;
    e.len   = (f + 1) << b;
    e.mid   = (f >> 1) << b;
    e.ticks = f + 1;
    exp_q.push_back(e);
  endtask

  task automatic close_phase();
    exp_t e;
    nvec++;
    if (exp_q.size() == 0) begin
      nerr++;
      $display("FAIL R1 unexpected phase hi=%0d len=%0d actual, none expected", cur_hi, cnt + 1);
    end else begin
      e = exp_q.pop_front();
      if (e.hi !== cur_hi || e.len != cnt + 1 || e.mid != mid_at || e.ticks != tk || !ok) begin
        nerr++;
        $display("FAIL R1/R8/R9/R10 phase actual hi=%0d len=%0d mid=%0d ticks=%0d strobes_ok=%0d expected hi=%0d len=%0d mid=%0d ticks=%0d strobes_ok=1",
                 cur_hi, cnt + 1, mid_at, tk, ok, e.hi, e.len, e.mid, e.ticks);
      end
    end
  endtask

  task automatic observe();
    if (scl_hi_ph !== cur_hi) ok = 1'b0;
    if (cnt == 0) begin
      if (rise_stb !== cur_hi || fall_stb !== !cur_hi) ok = 1'b0;
    end else if (rise_stb || fall_stb) begin
      ok = 1'b0;
    end
    if (cur_hi ? chg_stb : samp_stb) ok = 1'b0;
    if (cur_hi ? samp_stb : chg_stb) mid_at = (mid_at == -1) ? cnt : -2;
    if (pre_tick) tk++;
  endtask

  task automatic new_phase(input logic h);
    cur_hi = h;
    cnt    = 0;
    mid_at = -1;
    tk     = 0;
    ok     = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!mon_on) begin
      trk = 1'b0;
    end else begin
      if (trk && (scl_o !== cur_hi)) begin
        close_phase();
        new_phase(scl_o);
      end else if (trk) begin
        cnt++;
      end else if (fall_stb) begin
        trk = 1'b1;
        new_phase(1'b0);
      end
      if (trk) observe();
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic load(input logic [31:0] d, input bit keep);
    ld_en = 1'b1; ld_keep_hi = keep; ld_data = d;
    step();
    ld_en = 1'b0; ld_keep_hi = 1'b0;
  endtask

  task automatic run_until_drained();
    mon_on = 1'b1;
    enable = 1'b1;
    while (exp_q.size() != 0) step();
    mon_on = 1'b0;
    enable = 1'b0;
    step();
  endtask

  task automatic chk_idle(input string req);
    chk(scl_o === 1'b1 && scl_hi_ph === 1'b0 && pre_tick === 1'b0 &&
        {rise_stb, fall_stb, samp_stb, chg_stb} === 4'b0, req,
        {scl_o, scl_hi_ph, pre_tick, rise_stb, fall_stb, samp_stb, chg_stb}, 7'b1000000);
  endtask

  initial begin
    int c;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    // R7 reset state, R2 zero word
    chk_idle("R7 reset idle");
    chk(timing_q == 32'h0, "R2 reset word", timing_q, 32'h0);

    // R1 R9 R10: B=0 H=1 L=2
    load(32'h0001_2000, 1'b0);
    chk(timing_q == 32'h0001_2000, "R2 readback", timing_q, 32'h0001_2000);
    push_ph(0, 2, 0); push_ph(1, 1, 0); push_ph(0, 2, 0); push_ph(1, 1, 0);
    run_until_drained();
    chk_idle("R7 after disable");

    // R3 minimum counts with B=4
    load(32'h0000_0004, 1'b0);
    push_ph(0, 0, 4); push_ph(1, 0, 4); push_ph(0, 0, 4);
    run_until_drained();

    // R4 wide: H=15 L=8 B=1, bits 19 and 15 both count
    load(32'h000F_8001, 1'b0);
    chk(timing_q == 32'h000F_8001, "R4 wide readback", timing_q, 32'h000F_8001);
    chk(timing_n == 32'h0007_0001, "R4 narrow readback", timing_n, 32'h0007_0001);
    push_ph(0, 8, 1); push_ph(1, 15, 1); push_ph(0, 8, 1);
    run_until_drained();

    // R4 narrow instance: H=7 -> 16 cycles, L=0 -> 2 cycles
    en_nar = 1'b1;
    while (!rise_n) step();
    c = 0;
    while (scl_n) begin c++; step(); end
    chk(c == 16, "R4 narrow high length", c, 16);
    c = 0;
    while (!scl_n) begin c++; step(); end
    chk(c == 2, "R4 narrow low length", c, 2);
    en_nar = 1'b0;
    step();

    // R5 R6: full load B=1 H=2 L=1 upper ABC, then clock-only reload mid-high
    load(32'hABC2_1001, 1'b0);
    chk(timing_q[31:20] == 12'hABC, "R5 full load upper", timing_q[31:20], 12'hABC);
    push_ph(0, 1, 1); push_ph(1, 2, 1); push_ph(0, 1, 1);
    push_ph(1, 4, 0); push_ph(0, 3, 0); push_ph(1, 4, 0);
    mon_on = 1'b1;
    enable = 1'b1;
    while (!rise_stb) step();
    load(32'h1234_3000, 1'b1);
    chk(timing_q[31:20] == 12'hABC, "R5 upper kept", timing_q[31:20], 12'hABC);
    chk(timing_q[19:0] == 20'h21001, "R6 old fields still active", timing_q[19:0], 20'h21001);
    while (exp_q.size() != 0) step();
    chk(timing_q == 32'hABC4_3000, "R6 new fields active", timing_q, 32'hABC4_3000);
    mon_on = 1'b0;
    enable = 1'b0;
    step();
    chk_idle("R7 idle again");

    // R6 load while stopped is immediate
    load(32'h5550_0002, 1'b1);
    chk(timing_q == 32'hABC0_0002, "R6 stopped load", timing_q, 32'hABC0_0002);
    push_ph(0, 0, 2); push_ph(1, 0, 2);
    run_until_drained();

    finish_run();
  end
endmodule